// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Controller

This block sits between a synchronous host and an asynchronous DRAM that shares one address bus between row and column. It turns each host request into a sequence of row-strobe, column-strobe, write-enable and output-enable levels. Every interval in that sequence is a whole number of clock cycles set by a parameter. A row is opened once. Later requests that fall in the same row are served by pulsing only the column strobe, so the row stays open across many accesses. The row is closed when the host stops presenting requests, when a request targets another row, when the row has been open as long as the device allows, or when a refresh arbiter asks for the memory.

The host side is a valid/ready request carrying a 20-bit address, a write flag and a data byte. The upper ten address bits select the row and the lower ten select the column. Read data returns with a one-cycle valid pulse. Writes always use the early-write ordering: write-enable goes low before the column strobe falls, and output-enable stays high for the whole access.

Top module: `fpm_ctrl`

## Requirements
- R1: After reset all four strobes (row, column, write, output-enable) are high (1) and `rd_valid` and `dq_oe` are 0. `req_ready` is high while `refresh_req` is low.
- R2: While the row strobe falls and stays low for the activate delay, `dram_addr` carries request address bits [19:10]. From the column setup cycle onward it carries bits [9:0].
- R3: The row strobe is low for `T_RCD` cycles before a column setup phase. Before every column-strobe fall, the column strobe is high for at least `T_CP` cycles with the column address already on the bus. The column strobe then stays low for exactly `T_CAS` cycles and is low only while the row strobe is low.
- R4: While a row is open, a request whose bits [19:10] equal the open row is accepted (`req_ready`=1) and served without the row strobe rising.
- R5: When a row closes, the row strobe stays high for at least `T_RP` cycles before it falls again. A request to a different row is not accepted until this precharge has passed and the controller is idle.
- R6: Each period with the row strobe low lasts at least `T_RAS_MIN` cycles. Within that period the row stays open even when there is no request.
- R7: Each period with the row strobe low lasts at most `T_RAS_MAX` cycles. A page hit is refused when serving it would overrun this limit, and the row is closed instead.
- R8: A write drives write-enable low and `dq_oe`=1 with the data on `dram_dq_out` from the column setup phase through the column-strobe-low phase. Output-enable stays high throughout.
- R9: A read keeps write-enable high and drives output-enable low while the column strobe is low. `dram_dq_in` is captured at the end of the last column-low cycle, and `rd_valid` pulses for one cycle in the next cycle with that byte on `rd_data`.
- R10: While `refresh_req` is high, no new row is opened and `req_ready` is 0 outside the open-row page-hit path, which is also blocked. An open row is closed as soon as R6 allows. `idle_ack` is 1 exactly when the controller is idle with the row strobe high and `refresh_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_addr | input | 20 | Row in [19:10], column in [9:0] |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse: read byte on rd_data |
| rd_data | output | 8 | Captured read byte |
| refresh_req | input | 1 | Refresh arbiter asks the controller to go idle |
| idle_ack | output | 1 | Controller idle with the row closed while refresh is requested |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Write data toward the pad cells |
| dram_dq_oe | output | 1 | Pad drive enable for write data |
| dram_dq_in | input | 8 | Read data from the pad cells |

## Verification
The bench runs a stream of back-to-back page hits that is long enough to hit the row-open ceiling. A controller that ignores the ceiling would hold the row strobe low past `T_RAS_MAX`, and the run-length monitor flags this. Row misses and idle gaps arrive shortly after a row opens, which probes the minimum open time: closing on demand would give a low pulse shorter than `T_RAS_MIN`. A refresh request raised while a page hit is waiting must win over that hit; a design that favoured the hit would keep issuing column cycles and never acknowledge. Written bytes are read back through a behavioural DRAM, so a swapped row/column multiplex or a late data capture shows up as wrong read data.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_RCD   = 3'd2,
    PH_SETUP = 3'd3,
    PH_CAS   = 3'd4,
    PH_OPEN  = 3'd5
  } phase_t;
endpackage

// File: rtl/fpm_timer.sv
module fpm_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_ras_window.sv
module fpm_ras_window #(
  parameter int T_RAS_MIN = 5,
  parameter int T_RAS_MAX = 10000,
  parameter int PAGE_CYC  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic min_met,
  output logic room
);
  localparam int CW       = $clog2(T_RAS_MAX + 1);
  localparam int ROOM_LIM = T_RAS_MAX - PAGE_CYC - 1;

  // cycles the row strobe has already been low before the current cycle
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (ras_low) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign min_met = (cnt_q >= CW'(T_RAS_MIN - 1));
  assign room    = (cnt_q <= CW'(ROOM_LIM));

  p_ras_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low |-> (cnt_q < CW'(T_RAS_MAX)));

  p_ras_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_low && $past(ras_low)) |-> ($past(cnt_q) >= CW'(T_RAS_MIN - 1)));
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl #(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 8,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 2,
  parameter int T_CP      = 1,
  parameter int T_CAS     = 3,
  parameter int T_RAS_MIN = 5,
  parameter int T_RAS_MAX = 10000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic                     req_we,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     refresh_req,
  output logic                     idle_ack,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]        dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DATA_W-1:0]        dram_dq_in
);
  import fpm_pkg::*;

  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int DA_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int D1       = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int D2       = (T_CP > T_CAS) ? T_CP : T_CAS;
  localparam int DMAX     = (D1 > D2) ? D1 : D2;
  localparam int TW       = $clog2(DMAX + 1);
  localparam int PAGE_CYC = T_CP + T_CAS + 1;

  phase_t            ph_q, ph_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;
  logic              win_min_met, win_room;
  logic              ras_low, row_hit, accept, rd_cap;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  assign ras_low = (ph_q == PH_RCD) || (ph_q == PH_SETUP) ||
                   (ph_q == PH_CAS) || (ph_q == PH_OPEN);
  assign row_hit = (req_addr[ADDR_W-1:COL_W] == row_q);

  fpm_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  fpm_ras_window #(.T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .PAGE_CYC(PAGE_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .ras_low(ras_low), .min_met(win_min_met), .room(win_room)
  );

  always_comb begin
    case (ph_q)
      PH_IDLE: req_ready = !refresh_req;
      PH_OPEN: req_ready = req_valid && row_hit && !refresh_req && win_room;
      default: req_ready = 1'b0;
    endcase
  end
  assign accept   = req_valid && req_ready;
  assign idle_ack = (ph_q == PH_IDLE) && refresh_req;

  // next-state
  always_comb begin
    ph_d     = ph_q;
    row_d    = row_q;
    col_d    = col_q;
    wr_d     = wr_q;
    wd_d     = wd_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      row_d = req_addr[ADDR_W-1:COL_W];
      col_d = req_addr[COL_W-1:0];
      wr_d  = req_we;
      wd_d  = req_wdata;
    end
    case (ph_q)
      PH_IDLE: if (accept) begin
        ph_d = PH_RCD; tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1);
      end
      PH_PRE: if (tmr_done) ph_d = PH_IDLE;
      PH_RCD: if (tmr_done) begin
        ph_d = PH_SETUP; tmr_load = 1'b1; tmr_val = TW'(T_CP - 1);
      end
      PH_SETUP: if (tmr_done) begin
        ph_d = PH_CAS; tmr_load = 1'b1; tmr_val = TW'(T_CAS - 1);
      end
      PH_CAS: if (tmr_done) ph_d = PH_OPEN;
      PH_OPEN: begin
        if (accept) begin
          ph_d = PH_SETUP; tmr_load = 1'b1; tmr_val = TW'(T_CP - 1);
        end else if (win_min_met) begin
          ph_d = PH_PRE; tmr_load = 1'b1; tmr_val = TW'(T_RP - 1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign rd_cap = (ph_q == PH_CAS) && tmr_done && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      wd_q       <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      ph_q       <= ph_d;
      row_q      <= row_d;
      col_q      <= col_d;
      wr_q       <= wr_d;
      wd_q       <= wd_d;
      rd_valid_q <= rd_cap;
      if (rd_cap) rd_data_q <= dram_dq_in;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // strobe decode
  always_comb begin
    dram_ras_n  = !ras_low;
    dram_cas_n  = (ph_q != PH_CAS);
    dram_we_n   = 1'b1;
    dram_oe_n   = 1'b1;
    dram_dq_oe  = 1'b0;
    dram_dq_out = wd_q;
    dram_addr   = DA_W'(col_q);
    if ((ph_q == PH_IDLE) || (ph_q == PH_PRE) || (ph_q == PH_RCD))
      dram_addr = DA_W'(row_q);
    if ((ph_q == PH_SETUP) || (ph_q == PH_CAS)) begin
      dram_we_n  = !wr_q;
      dram_dq_oe = wr_q;
      dram_oe_n  = wr_q || (ph_q != PH_CAS);
    end
  end

  p_cas_in_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  p_we_before_cas_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

  p_no_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (!dram_dq_oe && dram_we_n));

  p_ack_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ack |-> (dram_ras_n && !req_ready));
endmodule

// File: tb/tb_fpm_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_ctrl;
  localparam int RP = 3, RCD = 2, CP = 1, CAS = 3, RMIN = 8, RMAX = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, refresh_req = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, idle_ack;
  logic [7:0] rd_data, dq_out;
  logic [7:0] dq_in = '0;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [9:0] daddr;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fpm_ctrl #(.T_RP(RP), .T_RCD(RCD), .T_CP(CP), .T_CAS(CAS),
             .T_RAS_MIN(RMIN), .T_RAS_MAX(RMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .refresh_req(refresh_req),
    .idle_ack(idle_ack), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(daddr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] seed_byte(input logic [19:0] a);
    return a[7:0] ^ a[17:10] ^ 8'h5a;
  endfunction

  // host-level memory view and expected read bytes
  logic [7:0] hmem [int];
  logic [7:0] rdq [$];

  // behavioural reference: 0 idle,1 precharge,2 activate,3 col setup,4 col low,5 open
  int ph, left, lowcnt;
  logic [9:0] m_row, m_col;
  logic m_wr, m_rdv;
  logic [7:0] m_wd, m_rdexp;

  function automatic bit m_ready();
    bit hit;
    hit = (req_addr[19:10] == m_row);
    if (ph == 0) return !refresh_req;
    if (ph == 5) return req_valid && hit && !refresh_req && (lowcnt + 1 + CP + CAS + 1 <= RMAX);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; left = 0; lowcnt = 0; m_row = '0; m_col = '0;
      m_wr = 0; m_wd = '0; m_rdv = 0; m_rdexp = '0;
    end else begin
      bit acc, low_now;
      acc = req_valid && m_ready();
      low_now = (ph >= 2);
      m_rdv = (ph == 4 && left == 0 && !m_wr);
      if (m_rdv) m_rdexp = rdq.pop_front();
      if (acc) begin
        m_row = req_addr[19:10]; m_col = req_addr[9:0];
        m_wr = req_we; m_wd = req_wdata;
        if (req_we) hmem[int'(req_addr)] = req_wdata;
        else rdq.push_back(hmem.exists(int'(req_addr)) ? hmem[int'(req_addr)] : seed_byte(req_addr));
      end
      case (ph)
        0: if (acc) begin ph = 2; left = RCD - 1; end
        1: if (left == 0) ph = 0; else left--;
        2: if (left == 0) begin ph = 3; left = CP - 1; end else left--;
        3: if (left == 0) begin ph = 4; left = CAS - 1; end else left--;
        4: if (left == 0) ph = 5; else left--;
        5: if (acc) begin ph = 3; left = CP - 1; end
           else if (lowcnt + 1 >= RMIN) begin ph = 1; left = RP - 1; end
        default: ph = 0;
      endcase
      lowcnt = low_now ? lowcnt + 1 : 0;
    end
  end

  // behavioural DRAM and strobe run-length monitor
  logic [7:0] dmem [int];
  logic [9:0] lat_row;
  logic p_ras = 1'b1, p_cas = 1'b1;
  int low_run = 0, high_run = 100, cas_high_run = 100;

  always @(negedge clk) if (rst_n) begin
    if (p_ras && !ras_n) begin
      lat_row = daddr;
      chk(high_run >= RP, "R5", "precharge cycles", high_run, RP);
    end
    if (!p_ras && ras_n) begin
      chk(low_run >= RMIN, "R6", "row low cycles", low_run, RMIN);
      chk(low_run <= RMAX, "R7", "row low cycles", low_run, RMAX);
    end
    if (p_cas && !cas_n) begin
      chk(cas_high_run >= CP, "R3", "cas high cycles", cas_high_run, CP);
      if (!we_n) begin
        chk(dq_oe, "R8", "dq_oe at cas fall", dq_oe, 1);
        dmem[int'({lat_row, daddr})] = dq_out;
      end
    end
    if (!cas_n && !oe_n) begin
      int k;
      k = int'({lat_row, daddr});
      dq_in = dmem.exists(k) ? dmem[k] : seed_byte({lat_row, daddr});
    end else dq_in = 8'h00;
    low_run      = ras_n ? 0 : low_run + 1;
    high_run     = ras_n ? high_run + 1 : 0;
    cas_high_run = cas_n ? cas_high_run + 1 : 0;
    p_ras = ras_n; p_cas = cas_n;
  end

  // per-cycle comparison against the reference
  always @(negedge clk) if (rst_n && !finished) begin
    logic [9:0] ea;
    ea = (ph <= 2) ? m_row : m_col;
    chk(ras_n == !(ph >= 2), "R6", "ras_n", ras_n, !(ph >= 2));
    chk(cas_n == (ph != 4), "R3", "cas_n", cas_n, ph != 4);
    chk(we_n == !((ph == 3 || ph == 4) && m_wr), "R8", "we_n", we_n, !((ph == 3 || ph == 4) && m_wr));
    chk(dq_oe == ((ph == 3 || ph == 4) && m_wr), "R8", "dq_oe", dq_oe, (ph == 3 || ph == 4) && m_wr);
    if (dq_oe) chk(dq_out == m_wd, "R8", "dq_out", dq_out, m_wd);
    chk(oe_n == !(ph == 4 && !m_wr), "R9", "oe_n", oe_n, !(ph == 4 && !m_wr));
    chk(daddr == ea, "R2", "dram_addr", daddr, ea);
    chk(req_ready == m_ready(), "R4", "req_ready", req_ready, m_ready());
    chk(idle_ack == (ph == 0 && refresh_req), "R10", "idle_ack", idle_ack, ph == 0 && refresh_req);
    chk(rd_valid == m_rdv, "R9", "rd_valid", rd_valid, m_rdv);
    if (m_rdv) chk(rd_data == m_rdexp, "R9", "rd_data", rd_data, m_rdexp);
  end

  task automatic issue(input logic [9:0] r, input logic [9:0] c, input bit w, input logic [7:0] d);
    bit got;
    req_valid = 1'b1; req_addr = {r, c}; req_we = w; req_wdata = d;
    do begin
      #2; got = req_ready;
      @(negedge clk); #1;
    end while (!got);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes", {ras_n, cas_n, we_n, oe_n}, 4'hf);
    chk(!rd_valid && !dq_oe, "R1", "rd_valid/dq_oe", {rd_valid, dq_oe}, 0);
    chk(req_ready, "R1", "req_ready", req_ready, 1);
    #1 rst_n = 1'b1;
    idle(2);
    // R4/R8/R9 page hits with write then read-back
    issue(10'd5, 10'd3, 1, 8'hA1);
    issue(10'd5, 10'd3, 0, 8'h00);
    issue(10'd5, 10'd7, 0, 8'h00);
    issue(10'd5, 10'd7, 1, 8'h3C);
    issue(10'd5, 10'd7, 0, 8'h00);
    // R5 row miss
    issue(10'd9, 10'd1, 0, 8'h00);
    issue(10'd5, 10'd3, 0, 8'h00);
    idle(20);
    // R6 short burst after open, then idle
    issue(10'h3FF, 10'h3FF, 1, 8'hEE);
    idle(15);
    issue(10'h3FF, 10'h3FF, 0, 8'h00);
    idle(15);
    // R7 long run of hits
    for (int i = 0; i < 12; i++) issue(10'd20, 10'(i), 1, 8'(i * 7 + 1));
    for (int i = 0; i < 12; i++) issue(10'd20, 10'(i), 0, 8'h00);
    idle(20);
    // R10 refresh while idle
    refresh_req = 1'b1;
    idle(6);
    refresh_req = 1'b0;
    idle(2);
    // R10 refresh while a row is open with a hit pending
    issue(10'd3, 10'd1, 1, 8'h77);
    refresh_req = 1'b1;
    fork
      issue(10'd3, 10'd2, 0, 8'h00);
      begin idle(25); refresh_req = 1'b0; end
    join
    issue(10'd3, 10'd1, 0, 8'h00);
    idle(25);
    chk(rdq.size() == 0, "R9", "reads outstanding", rdq.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule